// File: doc/BRIEF.md
# Receive Byte Ordering Aligner

This block sits in a receive path behind a deserializer that hands over two symbols per clock. The symbol in the low lane comes first in time. The block watches the stream for a programmable ordering symbol. It can also watch for a pair of them, one straight after the other. Downstream logic expects that marker in the low lane. When the marker turns up in the high lane, the block inserts one pad symbol just ahead of it. From then on the marker and every later symbol leave one lane lower than they arrived. After that insertion, each output word is built from the low symbol of the current word and the high symbol held back from the word before.

The block looks one word ahead so that it can spot a marker pair that straddles two words. For that reason a word leaves the block only once the next valid word has come in. The output is registered one clock after that arrival. Static inputs set the marker, the pad value, whether one or two markers are searched, and the mode. In automatic mode the block performs one operation after reset. In manual mode it performs one operation per rising level of a request input. A status flag marks the output word on which an operation took effect. The symbol width is a parameter: 8 for plain bytes, 9 for decoded 8B/10B data (eight bits plus a control indicator), or 10 for raw 10-bit symbols.

Top module: `rx_byte_orderer`

## Requirements
- R1: Before any lane shift, each valid input word {high, low} appears unchanged on `out_data`. It appears with `out_valid` high one clock after the next valid input word is accepted.
- R2: In single-symbol mode (`cfg_pair`=0), with no shift yet, a word whose low lane is not the marker but whose high lane is produces the output {pad, low}. Every later output is {current low, previous high}.
- R3: A marker found in the current low lane (in the lane view then in force) is an operation that changes nothing. The flag pulses and the lane mapping stays as it was.
- R4: In pair mode (`cfg_pair`=1), a word with the marker in both lanes is a low-lane hit. A marker in a word's high lane followed by a marker in the next valid word's low lane causes the pad insertion of R2. A lone marker causes no operation.
- R5: `order_flag` is high for exactly one clock, together with `out_valid`, on the output word that carries the inserted pad or the marker found in the low lane.
- R6: In manual mode (`cfg_manual`=1), no operation happens until `order_req` is seen high. A request is latched, so a one-clock pulse enables the next marker found. After an operation, `order_req` must be seen low and then high again before another one.
- R7: In automatic mode (`cfg_manual`=0), exactly one operation is performed, on the first marker found after reset. Later markers cause no operation until the next reset.
- R8: Once shifted, the mapping stays shifted until reset. A later operation is taken only when the marker sits in the low lane of the realigned output. A marker in the realigned high lane leaves the request pending.
- R9: No symbol is dropped or reordered. The output symbol stream equals the input symbol stream with exactly one pad inserted per shift.
- R10: While `rst_n` is sampled low, the stage, the held symbol, the shift state, the request latch and the flag are cleared. `out_valid` and `order_flag` are low on the following clock.
- R11: An input word with `in_valid` low is ignored: it produces no output, does not advance the pipeline, and a marker on it triggers nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_pattern | input | SYM_W | Ordering symbol searched for (static) |
| cfg_pad | input | SYM_W | Pad symbol inserted on a shift (static) |
| cfg_pair | input | 1 | 0: search one marker, 1: search two consecutive markers |
| cfg_manual | input | 1 | 0: automatic single operation, 1: operations on request |
| order_req | input | 1 | Manual operation request, level sensitive, re-armed by going low |
| in_valid | input | 1 | Input word valid |
| in_data | input | 2*SYM_W | Input word, {high lane, low lane} |
| out_valid | output | 1 | Output word valid |
| out_data | output | 2*SYM_W | Output word, {high lane, low lane} |
| order_flag | output | 1 | High on the output word where an operation took effect |

## Verification
A behavioural symbol-queue model follows the stream through markers in the low lane, in the high lane, as aligned pairs, as straddling pairs and as lone markers. These cases separate a true shift from a no-change operation and show whether the lookahead uses the right word. The manual sequence places markers before the request, after a one-clock request pulse, under a held request, and in both lanes of the realigned stream. It shows whether the request latch and its re-arm gate operations correctly. Gaps in `in_valid` carrying marker values, and a reset in mid-stream, show that idle words are skipped and that state returns to pass-through.

// File: rtl/rx_ord_pkg.sv
// Package: shared constants and types for the receive byte ordering aligner.
// Assumes a two-lane word, low lane first in time.
package rx_ord_pkg;
    localparam int LANES = 2;

    typedef enum logic {
        MAP_DIRECT  = 1'b0,
        MAP_SHIFTED = 1'b1
    } lane_map_e;
endpackage

// File: rtl/rx_ord_arm.sv
// rx_ord_arm: decides whether an ordering operation is allowed.
// Automatic mode: one operation allowed after reset.
// Manual mode: a request level latches permission once. The request must be
// seen low before it can latch again. Assumes 'fire' is high for one clock per
// operation.
module rx_ord_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_manual,
    input  logic order_req,
    input  logic fire,
    output logic pending
);
    logic ready;

    // Request latch and re-arm gate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready   <= 1'b1;
            pending <= !cfg_manual;
        end else if (cfg_manual) begin
            if (!order_req)
                ready <= 1'b1;
            else if (ready)
                ready <= 1'b0;
            if (order_req && ready)
                pending <= 1'b1;
            else if (fire)
                pending <= 1'b0;
        end else if (fire) begin
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_ord_match.sv
// rx_ord_match: compares the marker against the lane view now in force.
// Direct mapping views the stage word as is. Shifted mapping views
// {stage low, held high}. A high-lane hit is only meaningful in direct mapping.
// Pair mode uses the low symbol of the incoming word as lookahead.
// Purely combinational.
module rx_ord_match
    import rx_ord_pkg::*;
#(
    parameter int SYM_W = 10
) (
    input  logic [SYM_W-1:0]       cfg_pattern,
    input  logic                   cfg_pair,
    input  logic                   shifted,
    input  logic [LANES*SYM_W-1:0] stage_word,
    input  logic [SYM_W-1:0]       hold_sym,
    input  logic [SYM_W-1:0]       next_lo,
    output logic                   low_hit,
    output logic                   high_hit
);
    logic [LANES*SYM_W-1:0] view_word;
    logic [LANES-1:0]       view_eq;
    logic                   next_eq;

    // Lane view selected by the current mapping.
    always_comb view_word = shifted ? {stage_word[SYM_W-1:0], hold_sym} : stage_word;

    for (genvar g = 0; g < LANES; g++) begin : g_lane_cmp
        assign view_eq[g] = (view_word[g*SYM_W +: SYM_W] == cfg_pattern);
    end

    assign next_eq = (next_lo == cfg_pattern);

    // Hit classification: low lane first, high lane only in direct mapping.
    always_comb begin
        low_hit  = view_eq[0] && (!cfg_pair || view_eq[1]);
        high_hit = !shifted && !low_hit && view_eq[1] && (!cfg_pair || next_eq);
    end
endmodule

// File: rtl/rx_ord_lanes.sv
// rx_ord_lanes: one-word lookahead stage, held high symbol, lane mapping state
// and registered output. A stage word is emitted when the next valid word
// arrives. Assumes 'do_shift' is only high together with a step in direct
// mapping.
module rx_ord_lanes
    import rx_ord_pkg::*;
#(
    parameter int SYM_W = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [LANES*SYM_W-1:0] in_data,
    input  logic [SYM_W-1:0]       cfg_pad,
    input  logic                   fire,
    input  logic                   do_shift,
    output logic                   step,
    output logic                   shifted,
    output logic [LANES*SYM_W-1:0] stage_word,
    output logic [SYM_W-1:0]       hold_sym,
    output logic                   out_valid,
    output logic [LANES*SYM_W-1:0] out_data,
    output logic                   order_flag
);
    localparam int WORD_W = LANES * SYM_W;

    logic      stage_valid;
    lane_map_e lane_map;

    assign step    = in_valid && stage_valid;
    assign shifted = (lane_map == MAP_SHIFTED);

    // Lookahead stage: capture every valid input word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_valid <= 1'b0;
            stage_word  <= '0;
        end else if (in_valid) begin
            stage_valid <= 1'b1;
            stage_word  <= in_data;
        end
    end

    // Lane mapping: enter shifted mapping on a pad insertion, hold back the high symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_map <= MAP_DIRECT;
            hold_sym <= '0;
        end else if (step) begin
            if (shifted || do_shift)
                hold_sym <= stage_word[WORD_W-1:SYM_W];
            if (do_shift)
                lane_map <= MAP_SHIFTED;
        end
    end

    // Output register: word build, valid and operation flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            order_flag <= 1'b0;
            out_data   <= '0;
        end else begin
            out_valid  <= step;
            order_flag <= fire;
            if (step) begin
                if (shifted)
                    out_data <= {stage_word[SYM_W-1:0], hold_sym};
                else if (do_shift)
                    out_data <= {cfg_pad, stage_word[SYM_W-1:0]};
                else
                    out_data <= stage_word;
            end
        end
    end
endmodule

// File: rtl/rx_byte_orderer.sv
// rx_byte_orderer: top of the receive byte ordering aligner. It moves a
// detected ordering marker from the high lane to the low lane by inserting one
// pad symbol, in automatic or request-driven mode. Assumes the configuration
// inputs are static while rst_n is high.
module rx_byte_orderer
    import rx_ord_pkg::*;
#(
    parameter int SYM_W = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SYM_W-1:0]       cfg_pattern,
    input  logic [SYM_W-1:0]       cfg_pad,
    input  logic                   cfg_pair,
    input  logic                   cfg_manual,
    input  logic                   order_req,
    input  logic                   in_valid,
    input  logic [2*SYM_W-1:0]     in_data,
    output logic                   out_valid,
    output logic [2*SYM_W-1:0]     out_data,
    output logic                   order_flag
);
    localparam int WORD_W = LANES * SYM_W;

    logic              step;
    logic              shifted;
    logic [WORD_W-1:0] stage_word;
    logic [SYM_W-1:0]  hold_sym;
    logic              low_hit;
    logic              high_hit;
    logic              pending;
    logic              fire;
    logic              do_shift;

    // Operation decision: permission plus a hit on a step.
    always_comb begin
        fire     = step && pending && (low_hit || high_hit);
        do_shift = fire && high_hit;
    end

    rx_ord_arm u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_manual (cfg_manual),
        .order_req  (order_req),
        .fire       (fire),
        .pending    (pending)
    );

    rx_ord_match #(.SYM_W(SYM_W)) u_match (
        .cfg_pattern (cfg_pattern),
        .cfg_pair    (cfg_pair),
        .shifted     (shifted),
        .stage_word  (stage_word),
        .hold_sym    (hold_sym),
        .next_lo     (in_data[SYM_W-1:0]),
        .low_hit     (low_hit),
        .high_hit    (high_hit)
    );

    rx_ord_lanes #(.SYM_W(SYM_W)) u_lanes (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .cfg_pad    (cfg_pad),
        .fire       (fire),
        .do_shift   (do_shift),
        .step       (step),
        .shifted    (shifted),
        .stage_word (stage_word),
        .hold_sym   (hold_sym),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .order_flag (order_flag)
    );
endmodule

// File: rtl/rx_byte_orderer_chk.sv
// rx_byte_orderer_chk: port-level properties of the aligner, bound to the top.
// Assumes it observes only the top module's ports.
module rx_byte_orderer_chk #(
    parameter int SYM_W = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_manual,
    input logic               in_valid,
    input logic [2*SYM_W-1:0] in_data,
    input logic               out_valid,
    input logic [2*SYM_W-1:0] out_data,
    input logic               order_flag
);
    logic               flag_seen;
    logic [2*SYM_W-1:0] last_word;
    logic [2*SYM_W-1:0] prior_word;

    // Observation registers: flag history and the last two valid input words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_seen  <= 1'b0;
            last_word  <= '0;
            prior_word <= '0;
        end else begin
            if (order_flag)
                flag_seen <= 1'b1;
            if (in_valid) begin
                last_word  <= in_data;
                prior_word <= last_word;
            end
        end
    end

    assert_pass_through_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !flag_seen && !order_flag) |-> (out_data == prior_word));

    assert_flag_on_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        order_flag |-> out_valid);

    assert_auto_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_manual && flag_seen) |-> !order_flag);

    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !order_flag));

    assert_idle_no_output_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
endmodule

bind rx_byte_orderer rx_byte_orderer_chk #(.SYM_W(SYM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_manual (cfg_manual),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .order_flag (order_flag)
);

// File: tb/test_rx_byte_orderer.sv
// Bench: a symbol-queue reference model, compared on every falling edge.
module test_rx_byte_orderer;
    localparam int W = 10;
    localparam logic [W-1:0] PAT = 10'h17C;
    localparam logic [W-1:0] PAD = 10'h1BC;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [W-1:0]   cfg_pattern = PAT;
    logic [W-1:0]   cfg_pad = PAD;
    logic           cfg_pair = 1'b0;
    logic           cfg_manual = 1'b0;
    logic           order_req = 1'b0;
    logic           in_valid = 1'b0;
    logic [2*W-1:0] in_data = '0;
    logic           out_valid;
    logic [2*W-1:0] out_data;
    logic           order_flag;

    always #4 clk = ~clk;

    rx_byte_orderer #(.SYM_W(W)) i_rx_byte_orderer (
        .clk(clk), .rst_n(rst_n), .cfg_pattern(cfg_pattern), .cfg_pad(cfg_pad),
        .cfg_pair(cfg_pair), .cfg_manual(cfg_manual), .order_req(order_req),
        .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid),
        .out_data(out_data), .order_flag(order_flag)
    );

    int    checks = 0;
    int    errors = 0;
    int    dut_flags = 0;
    int    seed = 0;
    bit    running = 1'b0;
    bit    done = 1'b0;
    string tag = "R10";

    // Reference model state.
    logic [W-1:0]   mq[$];
    logic [W-1:0]   tmp_sym;
    logic [2*W-1:0] m_stage = '0;
    bit             m_sv = 1'b0;
    bit             m_ready = 1'b1;
    bit             m_pending = 1'b0;
    bit             lo_hit, hi_hit, m_fire;
    logic           exp_v = 1'b0;
    logic           exp_f = 1'b0;
    logic [2*W-1:0] exp_d = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_sv = 1'b0; m_stage = '0; m_ready = 1'b1; m_pending = !cfg_manual;
            exp_v = 1'b0; exp_f = 1'b0;
        end else begin
            exp_v = 1'b0; exp_f = 1'b0; m_fire = 1'b0;
            if (in_valid && m_sv) begin
                mq.push_back(m_stage[W-1:0]);
                mq.push_back(m_stage[2*W-1:W]);
                lo_hit = (mq[0] == PAT) && (!cfg_pair || mq[1] == PAT);
                hi_hit = !lo_hit && mq.size() == 2 && mq[1] == PAT &&
                         (!cfg_pair || in_data[W-1:0] == PAT);
                m_fire = m_pending && (lo_hit || hi_hit);
                if (m_fire && hi_hit) begin
                    tmp_sym = mq.pop_back();
                    mq.push_back(PAD);
                    mq.push_back(tmp_sym);
                end
                exp_d = {mq[1], mq[0]};
                void'(mq.pop_front());
                void'(mq.pop_front());
                exp_v = 1'b1;
                exp_f = m_fire;
            end
            if (in_valid) begin
                m_stage = in_data;
                m_sv = 1'b1;
            end
            if (cfg_manual) begin
                if (order_req && m_ready) m_pending = 1'b1;
                else if (m_fire)         m_pending = 1'b0;
                if (!order_req)   m_ready = 1'b1;
                else if (m_ready) m_ready = 1'b0;
            end else if (m_fire) begin
                m_pending = 1'b0;
            end
        end
    end

    // Per-clock comparison: valid, flag, and data when valid (R1 R2 R9 by phase tag).
    always @(negedge clk) begin
        if (running && !done) begin
            checks++;
            if (out_valid !== exp_v || order_flag !== exp_f || (exp_v && out_data !== exp_d)) begin
                errors++;
                $display("FAIL %s: valid/flag/data = %b/%b/%h expected %b/%b/%h",
                         tag, out_valid, order_flag, out_data, exp_v, exp_f, exp_d);
            end
            if (order_flag === 1'b1) dut_flags++;
        end
    end

    function automatic logic [W-1:0] dsym();
        seed = seed + 1;
        return W'((seed * 37 + 5) % 200);
    endfunction

    task automatic put(input logic v, input logic [W-1:0] hi, input logic [W-1:0] lo);
        @(negedge clk);
        in_valid = v;
        in_data  = {hi, lo};
    endtask

    task automatic words(input int n);
        for (int i = 0; i < n; i++) begin
            put(1'b1, dsym(), dsym());
            if (i % 3 == 2) put(1'b0, PAT, PAT);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(1'b0, dsym(), dsym());
    endtask

    task automatic do_reset(input logic manual, input logic pair);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; order_req = 1'b0;
        cfg_manual = manual; cfg_pair = pair;
        repeat (2) @(negedge clk);
        dut_flags = 0;
        rst_n = 1'b1;
    endtask

    task automatic check_count(input string t, input int expv);
        checks++;
        if (dut_flags != expv) begin
            errors++;
            $display("FAIL %s: operations = %0d expected %0d", t, dut_flags, expv);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        running = 1'b1;

        // R10: reset state, then R1 pass-through and R2 single-symbol high-lane shift, R7 auto once.
        tag = "R10"; do_reset(1'b0, 1'b0); idle(1);
        tag = "R1";  words(4);
        tag = "R2";  put(1'b1, PAT, dsym()); words(5);
        tag = "R7";  put(1'b1, PAT, dsym()); put(1'b1, dsym(), PAT); words(3); idle(3);
        check_count("R7", 1);

        // R3: low-lane marker, no shift.
        tag = "R3"; do_reset(1'b0, 1'b0);
        words(3); put(1'b1, dsym(), PAT); words(4); put(1'b1, PAT, dsym()); words(2); idle(3);
        check_count("R3", 1);

        // R4: pair mode, lone marker then straddling pair.
        tag = "R4"; do_reset(1'b0, 1'b1);
        words(3); put(1'b1, PAT, dsym()); put(1'b1, dsym(), dsym()); words(2);
        put(1'b1, PAT, dsym()); put(1'b1, dsym(), PAT); words(4); idle(3);
        check_count("R4", 1);

        // R4: pair mode, aligned pair in one word.
        tag = "R4"; do_reset(1'b0, 1'b1);
        words(2); put(1'b1, dsym(), PAT); put(1'b1, PAT, PAT); words(3); idle(3);
        check_count("R4", 1);

        // R6 and R8: manual mode latch, re-arm, realigned lane rules.
        tag = "R6"; do_reset(1'b1, 1'b0);
        words(2); put(1'b1, dsym(), PAT); words(2); idle(2);
        check_count("R6", 0);
        @(negedge clk); order_req = 1'b1;
        @(negedge clk); order_req = 1'b0;
        words(2); put(1'b1, PAT, dsym()); words(3); idle(2);
        check_count("R6", 1);
        tag = "R8"; order_req = 1'b1;
        put(1'b1, dsym(), PAT); words(3); idle(2);
        check_count("R8", 1);
        put(1'b1, PAT, dsym()); words(3); idle(2);
        check_count("R8", 2);
        tag = "R6"; put(1'b1, PAT, dsym()); words(3); idle(2);
        check_count("R6", 2);
        @(negedge clk); order_req = 1'b0;
        @(negedge clk); order_req = 1'b1;
        tag = "R9"; put(1'b1, PAT, dsym()); words(4); idle(3);
        check_count("R6", 3);

        // R11: idle words carrying markers are ignored.
        tag = "R11"; do_reset(1'b0, 1'b0);
        put(1'b0, PAT, PAT); put(1'b0, dsym(), PAT); words(3); idle(3);
        check_count("R11", 0);

        // R10: reset in mid-stream after a shift returns to pass-through.
        tag = "R10"; words(1); put(1'b1, PAT, dsym()); words(2);
        do_reset(1'b0, 1'b0);
        tag = "R1"; words(4); idle(3);
        check_count("R10", 0);
        tag = "R3"; put(1'b1, dsym(), PAT); words(3); idle(3);
        check_count("R3", 1);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
            $finish;
        end
    end
endmodule